// File: doc/BRIEF.md
# Shift-and-Add Output Accumulator Stage

This block sits at the output of an eight-cell multiply-accumulate filter array. It combines the partial sums that the cells produce. Each cell offers a 26-bit result. A 3-bit select picks one of them. The stage then either loads that value into its own 26-bit accumulator or adds it to the accumulator after the accumulator has been arithmetically shifted right by 8 bits.

The shift-and-add path exists so that a filter can use coefficients or samples wider than one 8-bit slice. The array runs several passes, one per slice. The partial result of a more significant slice is added to the previous total after that total is scaled down by one slice width. The lower bits that the shift drops have already been seen on the output during the pass that produced them.

The accumulator value leaves the block on a 26-bit bus. The bus has two independent enables: one for the low portion and one for the high portion. A disabled portion reads as zero. The accumulator changes only on a rising clock edge that has the valid strobe set.

Top module: `shadd_out_stage`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears the accumulator to zero, so `result` reads 0 with both enables high.
- R2: At a rising edge with rst low and valid low, the accumulator keeps its value.
- R3: At a rising edge with valid high and shadd low, the accumulator loads the selected cell value. No feedback term is added.
- R4: At a rising edge with valid high and shadd high, the accumulator becomes (accumulator >>> 8) + selected cell value. The shift is arithmetic: bit 25 is replicated into the 8 vacated upper bits.
- R5: The shift-add sum wraps modulo 2^26, with no saturation.
- R6: Cell k occupies bits [26*k+25 : 26*k] of `cell_bus`, and `sel` = k selects cell k, for every k from 0 to 7.
- R7: `result[15:0]` equals accumulator bits [15:0] when oe_lo is high and reads zero when it is low. `result[25:16]` equals accumulator bits [25:16] when oe_hi is high and reads zero when it is low. The two enables act independently and combinationally.
- R8: The output enables have no effect on the accumulator. Raising an enable again shows the unchanged value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear of the accumulator |
| valid | input | 1 | Update strobe for the accumulator |
| shadd | input | 1 | 1: shift-and-add, 0: load the selected value |
| sel | input | 3 | Index of the cell result to use |
| cell_bus | input | 208 | Eight 26-bit cell results, cell k at bits [26k+25:26k] |
| oe_lo | input | 1 | Enable for result bits [15:0] |
| oe_hi | input | 1 | Enable for result bits [25:16] |
| result | output | 26 | Accumulator value gated by the two enables |

## Verification
The bench loads a negative value and shifts it with a zero addend, expecting all ones. A logical shift would instead leave a large positive number. It adds two maximal positive values, expecting the wrapped negative result that a saturating or widened adder would not give. It steps `sel` through all eight cells with distinct patterns, so a misplaced slice or a swapped index shows up as the wrong value. It also drives every enable combination and then re-enables both halves, exposing an enable that is tied to the wrong half or that disturbs the stored value. Random runs mix holds, loads and shift-adds against a bench model.

// File: rtl/shadd_out_stage.sv
module shadd_out_stage #(
  parameter int CELLS = 8,
  parameter int W     = 26,
  parameter int LO_W  = 16,
  parameter int SHIFT = 8,
  localparam int SELW = $clog2(CELLS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               valid,
  input  logic               shadd,
  input  logic [SELW-1:0]    sel,
  input  logic [CELLS*W-1:0] cell_bus,
  input  logic               oe_lo,
  input  logic               oe_hi,
  output logic [W-1:0]       result
);

  logic        [W-1:0] cell_q [CELLS];
  logic signed [W-1:0] picked;
  logic signed [W-1:0] acc;
  logic signed [W-1:0] acc_nx;

  for (genvar k = 0; k < CELLS; k++) begin : g_unpack
    assign cell_q[k] = cell_bus[k*W +: W];
  end

  assign picked = $signed(cell_q[sel]);
  assign acc_nx = shadd ? (acc >>> SHIFT) + picked : picked;

  always_ff @(posedge clk) begin
    if (rst)        acc <= '0;
    else if (valid) acc <= acc_nx;
  end

  assign result[LO_W-1:0] = oe_lo ? acc[LO_W-1:0] : {LO_W{1'b0}};
  assign result[W-1:LO_W] = oe_hi ? acc[W-1:LO_W] : {(W-LO_W){1'b0}};

endmodule

module shadd_out_stage_chk #(
  parameter int CELLS = 8,
  parameter int W     = 26,
  parameter int LO_W  = 16,
  parameter int SHIFT = 8,
  localparam int SELW = $clog2(CELLS)
) (
  input logic               clk,
  input logic               rst,
  input logic               valid,
  input logic               shadd,
  input logic [SELW-1:0]    sel,
  input logic [CELLS*W-1:0] cell_bus,
  input logic               oe_lo,
  input logic               oe_hi,
  input logic signed [W-1:0] acc,
  input logic [W-1:0]       result
);
  logic signed [W-1:0] chosen;
  assign chosen = $signed(cell_bus[int'(sel)*W +: W]);

  p_clear_r1: assert property (@(posedge clk) rst |=> acc == '0);

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !valid |=> $stable(acc));

  p_load_r3: assert property (@(posedge clk) disable iff (rst)
    valid && !shadd |=> acc == $past(chosen));

  p_shadd_r4: assert property (@(posedge clk) disable iff (rst)
    valid && shadd |=> acc == W'(($past(acc) >>> SHIFT) + $past(chosen)));

  p_lo_gate_r7: assert property (@(posedge clk) disable iff (rst)
    !oe_lo |-> result[LO_W-1:0] == '0);

  p_hi_gate_r7: assert property (@(posedge clk) disable iff (rst)
    !oe_hi |-> result[W-1:LO_W] == '0);

  p_pass_both_r7: assert property (@(posedge clk) disable iff (rst)
    oe_lo && oe_hi |-> result == acc);
endmodule

bind shadd_out_stage shadd_out_stage_chk #(
  .CELLS(CELLS), .W(W), .LO_W(LO_W), .SHIFT(SHIFT)
) u_chk (
  .clk(clk), .rst(rst), .valid(valid), .shadd(shadd), .sel(sel),
  .cell_bus(cell_bus), .oe_lo(oe_lo), .oe_hi(oe_hi), .acc(acc), .result(result)
);

// File: tb/shadd_out_stage_test.sv
module shadd_out_stage_test;
  localparam int CELLS = 8;
  localparam int W = 26;
  localparam int LO_W = 16;

  logic clk = 1'b0;
  logic rst, valid, shadd, oe_lo, oe_hi;
  logic [2:0] sel;
  logic [W-1:0] cells [CELLS];
  logic [CELLS*W-1:0] cell_bus;
  logic [W-1:0] result;
  logic [W-1:0] model;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  always_comb
    for (int k = 0; k < CELLS; k++) cell_bus[k*W +: W] = cells[k];

  shadd_out_stage uut (
    .clk(clk), .rst(rst), .valid(valid), .shadd(shadd), .sel(sel),
    .cell_bus(cell_bus), .oe_lo(oe_lo), .oe_hi(oe_hi), .result(result)
  );

  function automatic logic [W-1:0] next_acc(logic [W-1:0] a, logic [W-1:0] v, logic sa);
    logic signed [W-1:0] sa_v;
    sa_v = $signed(a) >>> 8;
    return sa ? W'(sa_v + $signed(v)) : v;
  endfunction

  function automatic logic [W-1:0] gate(logic [W-1:0] a, logic lo, logic hi);
    logic [W-1:0] r;
    r = a;
    if (!lo) r[LO_W-1:0] = '0;
    if (!hi) r[W-1:LO_W] = '0;
    return r;
  endfunction

  task automatic check(string req, logic [W-1:0] exp);
    checks++;
    if (result !== exp) begin
      errors++;
      $display("FAIL %s: result=%h expected=%h", req, result, exp);
    end
  endtask

  task automatic step(logic v, logic sa, logic [2:0] s, logic lo, logic hi, string req);
    @(negedge clk);
    valid = v; shadd = sa; sel = s; oe_lo = lo; oe_hi = hi;
    @(posedge clk);
    #1;
    if (v) model = next_acc(model, cells[s], sa);
    check(req, gate(model, lo, hi));
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog: result=%h expected=done", result);
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; valid = 1'b0; shadd = 1'b0; sel = '0; oe_lo = 1'b1; oe_hi = 1'b1;
    for (int k = 0; k < CELLS; k++) cells[k] = W'(32'h0111111 * (k + 1) + k);
    model = '0;
    repeat (3) @(posedge clk);
    #1 check("R1 reset", '0);
    @(negedge clk) rst = 1'b0;

    // R6 and R3: load each cell in turn
    for (int k = 0; k < CELLS; k++) step(1'b1, 1'b0, 3'(k), 1'b1, 1'b1, "R6/R3 select-load");

    // R4: arithmetic shift keeps sign
    cells[2] = 26'h3FFFF00; cells[3] = '0;
    step(1'b1, 1'b0, 3'd2, 1'b1, 1'b1, "R3 load negative");
    step(1'b1, 1'b1, 3'd3, 1'b1, 1'b1, "R4 sign extend");
    check("R4 all ones", 26'h3FFFFFF);

    // R5: wrap
    cells[4] = 26'h1FFFFFF;
    step(1'b1, 1'b0, 3'd4, 1'b1, 1'b1, "R3 load max");
    step(1'b1, 1'b1, 3'd4, 1'b1, 1'b1, "R5 wrap");
    check("R5 wrapped value", 26'h201FFFE);

    // R2: hold
    cells[4] = 26'h0ABCDEF;
    step(1'b0, 1'b1, 3'd4, 1'b1, 1'b1, "R2 hold");
    step(1'b0, 1'b0, 3'd1, 1'b1, 1'b1, "R2 hold load");

    // R7 and R8: enable combinations
    step(1'b0, 1'b0, 3'd0, 1'b0, 1'b1, "R7 low off");
    step(1'b0, 1'b0, 3'd0, 1'b1, 1'b0, "R7 high off");
    step(1'b0, 1'b0, 3'd0, 1'b0, 1'b0, "R7 both off");
    step(1'b1, 1'b0, 3'd5, 1'b0, 1'b0, "R8 load while off");
    step(1'b0, 1'b0, 3'd5, 1'b1, 1'b1, "R8 reenable");
    check("R8 value kept", cells[5]);

    // random mix
    for (int i = 0; i < 400; i++) begin
      if (i % 16 == 0)
        for (int k = 0; k < CELLS; k++) cells[k] = W'($urandom);
      step(($urandom % 4) != 0, $urandom % 2 == 1, 3'($urandom), ($urandom % 4) != 0,
           ($urandom % 4) != 0, "R2-R7 random");
    end

    // R1: reset mid-run
    @(negedge clk) rst = 1'b1; oe_lo = 1'b1; oe_hi = 1'b1;
    @(posedge clk); #1;
    model = '0;
    check("R1 mid reset", '0);
    @(negedge clk) rst = 1'b0;
    finish_run();
  end
endmodule